// File: doc/BRIEF.md
# Multi-Context Logic Cluster

This block groups four logic elements that each evaluate a 4-input lookup table. A private crossbar gives every element its four lookup inputs. The crossbar draws from twelve sources: eight external cluster inputs and the four registered element outputs. The truth tables and the crossbar select codes are both stored per context. All four elements share one context index, so when the cluster folds a larger function onto itself over time, the routing and the logic switch in the same clock edge.

Configuration words go into a per-element context store through a write port. A small sequencer steps the shared context index. Each context stays active for a programmable number of run cycles (the dwell). After the last context in use, the index wraps to zero. Each element copies its active word from the store into working cells, and the lookup and crossbar logic read only from those working cells. The cluster drives eight outputs: two per element, one registered and one combinational.

Top module: `lc_cluster`

## Requirements
- R1: After reset every stored and working configuration word is zero, the context index is 0, and all eight outputs are 0.
- R2: In a configuration word, bits [16+4i+3:16+4i] hold the select code of lookup input i. Codes 0 to 7 pick external input `x_in[code]`. Codes 8 to 11 pick the registered output of element code-8.
- R3: A select code of 12 to 15 drives a constant 0 into that lookup input.
- R4: Bits [15:0] of the working word are the truth table. The combinational output `y_out[2e+1]` equals bit {in3,in2,in1,in0} of element e's table.
- R5: `y_out[2e]` is element e's flip-flop. It captures the combinational value on each clock edge where `run` is 1 and holds while `run` is 0.
- R6: While `run` is 1, a dwell counter counts cycles. When the counter is at or above `dwell`, the next edge clears it and advances the context: to 0 if the index is at or above `ctx_last`, otherwise to index+1. While `run` is 0, the index and the counter hold.
- R7: While `run` is 0, the working cells reload from the store entry of the current context on every edge, so a write shows at the outputs one cycle after its edge.
- R8: While `run` is 1, the working cells reload only on the edge where the context advances, and they take the stored word of the new context as it stood before that edge. A write during a dwell therefore leaves the active configuration unchanged.
- R9: A write with `cfg_we` high replaces the stored word for (`cfg_ctx`, `cfg_elem`) and no other. Each context keeps its own truth tables and its own selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Enables flip-flop capture and context stepping |
| dwell | input | 4 | Cycles per context minus one |
| ctx_last | input | 2 | Highest context index in the folding sequence |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ctx | input | 2 | Context addressed by the write |
| cfg_elem | input | 2 | Element addressed by the write |
| cfg_word | input | 32 | Configuration word: table in [15:0], selects in [31:16] |
| x_in | input | 8 | External cluster inputs |
| y_out | output | 8 | Even bit 2e: registered value of element e; odd bit 2e+1: its lookup value |
| ctx_idx | output | 2 | Active context index |

## Verification
The assertions assume that `dwell` and `ctx_last` are held constant across the edge on which the sequencer advances. They also assume that reset is applied once, before any traffic. The stimulus changes `dwell` and `ctx_last` only in phases that leave them steady for many cycles, so the step and wrap checks always see settled settings. Select codes are drawn over the full 4-bit range. Random selects therefore reach dead codes and feedback codes as well as external inputs, and they stay within the encoding the requirements define.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int unsigned LC_ELEMS = 4;
  localparam int unsigned LC_LUT_K = 4;
  localparam int unsigned LC_EXT   = 8;
  localparam int unsigned LC_CTXS  = 4;
  localparam int unsigned LC_DWELL_W = 4;

  function automatic int unsigned cfg_width(int unsigned k, int unsigned sel_w);
    return (2 ** k) + k * sel_w;
  endfunction
endpackage

// File: rtl/lc_ctx_seq.sv
module lc_ctx_seq #(
  parameter int unsigned N_CTX   = 4,
  parameter int unsigned DWELL_W = 4,
  localparam int unsigned CTX_W  = $clog2(N_CTX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [DWELL_W-1:0] dwell,
  input  logic [CTX_W-1:0]   ctx_last,
  output logic [CTX_W-1:0]   ctx_q,
  output logic [CTX_W-1:0]   ctx_d,
  output logic               adv
);
  logic [DWELL_W-1:0] cnt_q, cnt_d;
  logic               cnt_en;

  always_comb begin
    adv    = run && (cnt_q >= dwell);
    cnt_en = run;
    cnt_d  = adv ? '0 : cnt_q + 1'b1;
    ctx_d  = ctx_q;
    if (adv) begin
      ctx_d = (ctx_q >= ctx_last) ? '0 : ctx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ctx_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      ctx_q <= ctx_d;
    end
  end

  assert_ctx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(ctx_q));
  assert_ctx_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (ctx_q >= ctx_last)) |=> (ctx_q == '0));
  assert_ctx_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (ctx_q < ctx_last)) |=> (ctx_q == $past(ctx_q) + 1'b1));
  assert_ctx_dwell_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !adv) |=> $stable(ctx_q));
endmodule

// File: rtl/lc_cfg_slot.sv
module lc_cfg_slot #(
  parameter int unsigned N_CTX = 4,
  parameter int unsigned CFG_W = 32,
  localparam int unsigned CTX_W = $clog2(N_CTX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTX_W-1:0] wr_ctx,
  input  logic [CFG_W-1:0] wr_word,
  input  logic             load_en,
  input  logic [CTX_W-1:0] load_ctx,
  output logic [CFG_W-1:0] work_word
);
  logic [CFG_W-1:0] store_q [N_CTX];
  logic [CFG_W-1:0] store_d [N_CTX];
  logic [CFG_W-1:0] work_q, work_d;

  always_comb begin
    for (int c = 0; c < N_CTX; c++) begin
      store_d[c] = store_q[c];
    end
    if (wr_en) begin
      store_d[wr_ctx] = wr_word;
    end
    work_d = load_en ? store_q[load_ctx] : work_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < N_CTX; c++) begin
        store_q[c] <= '0;
      end
      work_q <= '0;
    end else begin
      for (int c = 0; c < N_CTX; c++) begin
        store_q[c] <= store_d[c];
      end
      work_q <= work_d;
    end
  end

  assign work_word = work_q;

  assert_work_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(work_word));
endmodule

// File: rtl/lc_xbar.sv
module lc_xbar #(
  parameter int unsigned N_SRC = 12,
  parameter int unsigned K     = 4,
  parameter int unsigned SEL_W = 4
) (
  input  logic [N_SRC-1:0]   src,
  input  logic [K*SEL_W-1:0] sel_bus,
  output logic [K-1:0]       pick
);
  always_comb begin
    for (int i = 0; i < K; i++) begin
      pick[i] = 1'b0;
      if (int'(sel_bus[i*SEL_W +: SEL_W]) < N_SRC) begin
        pick[i] = src[sel_bus[i*SEL_W +: SEL_W]];
      end
    end
  end
endmodule

// File: rtl/lc_elem.sv
module lc_elem #(
  parameter int unsigned N_SRC = 12,
  parameter int unsigned K     = 4,
  parameter int unsigned SEL_W = 4,
  localparam int unsigned TBL_W = 2 ** K,
  localparam int unsigned CFG_W = TBL_W + K * SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [N_SRC-1:0] src,
  output logic             q,
  output logic             f
);
  logic [K-1:0] lut_in;
  logic [K-1:0] dead;
  logic         q_d;

  lc_xbar #(.N_SRC(N_SRC), .K(K), .SEL_W(SEL_W)) i_xbar (
    .src     (src),
    .sel_bus (cfg_word[CFG_W-1:TBL_W]),
    .pick    (lut_in)
  );

  always_comb begin
    f   = cfg_word[lut_in];
    q_d = f;
    for (int i = 0; i < K; i++) begin
      dead[i] = int'(cfg_word[TBL_W + i*SEL_W +: SEL_W]) >= N_SRC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (run) begin
      q <= q_d;
    end
  end

  assert_ff_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(q));
  assert_ff_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (q == $past(f)));
  assert_dead_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (&dead) |-> (f == cfg_word[0]));
endmodule

// File: rtl/lc_cluster.sv
module lc_cluster
  import lc_pkg::*;
#(
  parameter int unsigned N_ELEM  = LC_ELEMS,
  parameter int unsigned K       = LC_LUT_K,
  parameter int unsigned N_EXT   = LC_EXT,
  parameter int unsigned N_CTX   = LC_CTXS,
  parameter int unsigned DWELL_W = LC_DWELL_W,
  localparam int unsigned N_SRC  = N_EXT + N_ELEM,
  localparam int unsigned SEL_W  = $clog2(N_SRC + 1),
  localparam int unsigned CFG_W  = cfg_width(K, SEL_W),
  localparam int unsigned CTX_W  = $clog2(N_CTX),
  localparam int unsigned ELEM_W = $clog2(N_ELEM)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [DWELL_W-1:0] dwell,
  input  logic [CTX_W-1:0]   ctx_last,
  input  logic               cfg_we,
  input  logic [CTX_W-1:0]   cfg_ctx,
  input  logic [ELEM_W-1:0]  cfg_elem,
  input  logic [CFG_W-1:0]   cfg_word,
  input  logic [N_EXT-1:0]   x_in,
  output logic [2*N_ELEM-1:0] y_out,
  output logic [CTX_W-1:0]   ctx_idx
);
  logic              rst_meta_q, rst_core_n;
  logic [CTX_W-1:0]  ctx_q, ctx_d;
  logic              adv, load_en;
  logic [N_ELEM-1:0] q_all, f_all;
  logic [N_SRC-1:0]  src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  lc_ctx_seq #(.N_CTX(N_CTX), .DWELL_W(DWELL_W)) i_seq (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .run      (run),
    .dwell    (dwell),
    .ctx_last (ctx_last),
    .ctx_q    (ctx_q),
    .ctx_d    (ctx_d),
    .adv      (adv)
  );

  always_comb begin
    load_en = !run || adv;
    src     = {q_all, x_in};
  end

  for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
    logic [CFG_W-1:0] work;
    logic             wr_sel;

    assign wr_sel = cfg_we && (cfg_elem == ELEM_W'(e));

    lc_cfg_slot #(.N_CTX(N_CTX), .CFG_W(CFG_W)) i_slot (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .wr_en     (wr_sel),
      .wr_ctx    (cfg_ctx),
      .wr_word   (cfg_word),
      .load_en   (load_en),
      .load_ctx  (ctx_d),
      .work_word (work)
    );

    lc_elem #(.N_SRC(N_SRC), .K(K), .SEL_W(SEL_W)) i_elem (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .run      (run),
      .cfg_word (work),
      .src      (src),
      .q        (q_all[e]),
      .f        (f_all[e])
    );

    assign y_out[2*e]   = q_all[e];
    assign y_out[2*e+1] = f_all[e];
  end

  assign ctx_idx = ctx_q;

  assert_idle_ctx_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    !run |=> (ctx_idx == $past(ctx_idx)));
  assert_regs_hold_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    !run |=> (q_all == $past(q_all)));
endmodule

// File: tb/test_lc_cluster.sv
module test_lc_cluster;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [3:0]  dwell = '0;
  logic [1:0]  ctx_last = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ctx = '0;
  logic [1:0]  cfg_elem = '0;
  logic [31:0] cfg_word = '0;
  logic [7:0]  x_in = '0;
  logic [7:0]  y_out;
  logic [1:0]  ctx_idx;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  logic [31:0] m_store [4][4];
  logic [31:0] m_work [4];
  logic [3:0]  m_reg;
  logic [1:0]  m_ctx;
  logic [3:0]  m_cnt;

  lc_cluster i_lc_cluster (
    .clk(clk), .rst_n(rst_n), .run(run), .dwell(dwell), .ctx_last(ctx_last),
    .cfg_we(cfg_we), .cfg_ctx(cfg_ctx), .cfg_elem(cfg_elem), .cfg_word(cfg_word),
    .x_in(x_in), .y_out(y_out), .ctx_idx(ctx_idx)
  );

  always #5 clk = ~clk;

  function automatic logic m_comb(int e);
    logic [11:0] src;
    logic [3:0]  idx;
    src = {m_reg, x_in};
    for (int i = 0; i < 4; i++) begin
      logic [3:0] s;
      s = m_work[e][16 + 4*i +: 4];
      idx[i] = (s < 4'd12) ? src[s] : 1'b0;
    end
    return m_work[e][idx];
  endfunction

  function automatic logic [7:0] m_y();
    logic [7:0] y;
    for (int e = 0; e < 4; e++) begin
      y[2*e]   = m_reg[e];
      y[2*e+1] = m_comb(e);
    end
    return y;
  endfunction

  task automatic cycle();
    logic [7:0]  exp_y;
    logic        adv;
    logic [1:0]  ctx_n;
    logic [3:0]  cnt_n;
    logic [3:0]  reg_n;
    logic [31:0] work_n [4];
    #1;
    exp_y = m_y();
    checks++;
    if (y_out !== exp_y || ctx_idx !== m_ctx) begin
      fails++;
      $display("FAIL %s: y_out=%h ctx_idx=%0d expected y_out=%h ctx_idx=%0d",
               cur_req, y_out, ctx_idx, exp_y, m_ctx);
    end
    adv   = run && (m_cnt >= dwell);
    ctx_n = adv ? ((m_ctx >= ctx_last) ? 2'd0 : m_ctx + 2'd1) : m_ctx;
    cnt_n = !run ? m_cnt : (adv ? 4'd0 : m_cnt + 4'd1);
    for (int e = 0; e < 4; e++) begin
      work_n[e] = (!run || adv) ? m_store[ctx_n][e] : m_work[e];
      reg_n[e]  = run ? m_comb(e) : m_reg[e];
    end
    @(posedge clk);
    if (cfg_we) m_store[cfg_ctx][cfg_elem] = cfg_word;
    for (int e = 0; e < 4; e++) m_work[e] = work_n[e];
    m_reg = reg_n;
    m_ctx = ctx_n;
    m_cnt = cnt_n;
    @(negedge clk);
  endtask

  task automatic write_cfg(logic [1:0] c, logic [1:0] e, logic [31:0] w);
    cfg_we = 1'b1; cfg_ctx = c; cfg_elem = e; cfg_word = w;
    cycle();
    cfg_we = 1'b0;
  endtask

  task automatic idle_rand(int n);
    for (int i = 0; i < n; i++) begin
      x_in = 8'($urandom);
      cycle();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < 4; c++)
      for (int e = 0; e < 4; e++) m_store[c][e] = '0;
    for (int e = 0; e < 4; e++) m_work[e] = '0;
    m_reg = '0; m_ctx = '0; m_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: outputs and context index after reset
    cur_req = "R1";
    idle_rand(3);

    // R2: external pick via code 5, then feedback pick via code 9
    cur_req = "R2";
    write_cfg(2'd0, 2'd0, 32'hFFF5_AAAA);
    idle_rand(8);
    write_cfg(2'd0, 2'd1, 32'hFFFF_FFFF);
    run = 1'b1; dwell = 4'd15; cycle(); run = 1'b0;
    write_cfg(2'd0, 2'd0, 32'hFFF9_AAAA);
    idle_rand(4);

    // R3: dead select codes feed zero
    cur_req = "R3";
    write_cfg(2'd0, 2'd0, 32'hFFFC_5555);
    idle_rand(6);
    write_cfg(2'd0, 2'd2, 32'hCDEF_5555);
    idle_rand(6);

    // R4: truth tables addressed by external picks
    cur_req = "R4";
    for (int k = 0; k < 6; k++) begin
      logic [15:0] sels;
      for (int i = 0; i < 4; i++) sels[4*i +: 4] = 4'($urandom % 8);
      write_cfg(2'd0, 2'(k), {sels, 16'($urandom)});
      idle_rand(12);
    end

    // R5: flip-flops capture only while running
    cur_req = "R5";
    dwell = 4'd15; ctx_last = 2'd0;
    for (int i = 0; i < 60; i++) begin
      run = ($urandom % 2) == 1;
      x_in = 8'($urandom);
      cycle();
    end
    run = 1'b0;

    // R6: context stepping and wrap for several dwell and last settings
    cur_req = "R6";
    for (int c = 0; c < 4; c++)
      for (int e = 0; e < 4; e++) write_cfg(2'(c), 2'(e), $urandom);
    dwell = 4'd1; ctx_last = 2'd2; run = 1'b1;
    idle_rand(20);
    dwell = 4'd0; ctx_last = 2'd3;
    idle_rand(12);
    run = 1'b0; ctx_last = 2'd1;
    idle_rand(2);
    run = 1'b1; dwell = 4'd2;
    idle_rand(14);
    run = 1'b0;

    // R7: idle writes become visible one cycle later
    cur_req = "R7";
    for (int k = 0; k < 8; k++) begin
      write_cfg(2'($urandom), 2'($urandom), $urandom);
      idle_rand(2);
    end
    write_cfg(ctx_idx, 2'd3, 32'hFFFF_0000);
    idle_rand(2);

    // R8: writes while running wait for the next load
    cur_req = "R8";
    dwell = 4'd5; ctx_last = 2'd3; run = 1'b1;
    for (int i = 0; i < 80; i++) begin
      cfg_we = ($urandom % 3) == 0;
      cfg_ctx = (($urandom % 2) == 0) ? m_ctx : 2'($urandom);
      cfg_elem = 2'($urandom); cfg_word = $urandom;
      x_in = 8'($urandom);
      cycle();
    end
    cfg_we = 1'b0; run = 1'b0;

    // R9: mixed random traffic across contexts, routing and tables
    cur_req = "R9";
    for (int i = 0; i < 3000; i++) begin
      if (i % 250 == 0) begin
        dwell = 4'($urandom % 4);
        ctx_last = 2'($urandom);
      end
      run = ($urandom % 4) != 0;
      cfg_we = ($urandom % 4) == 0;
      cfg_ctx = 2'($urandom); cfg_elem = 2'($urandom); cfg_word = $urandom;
      x_in = 8'($urandom);
      cycle();
    end
    cfg_we = 1'b0; run = 1'b0;
    idle_rand(2);
    finish_run();
  end
endmodule